// File: doc/BRIEF.md
# Bus-Attached Serial Port

This block is a bare serial port for a parallel host bus. It holds one 8-bit transmitter and one 8-bit receiver. The baud rate is fixed at elaboration by a parameter. The frame has no parity, and the transmitter sends one stop bit by default. The line has only TXD and RXD: there are no modem handshake pins and no FIFO.

The host reads the last received byte through a read strobe. A receive-ready flag rises when a good character has arrived and stays high until the host reads the port, however late that read comes. If another character lands first, it replaces the stored byte and an overrun flag goes high; the same read clears both flags. A host write starts a send only after a deliberate delay. The request is latched and then marched through a short shift chain that advances once per cycle of the bus phase clock. The serial frame begins when the request leaves the last stage. From the write until the end of the frame, further writes are dropped.

Top module: `bus_uart_port`

## Requirements
- R1: TXD idles high. A frame is a low start bit, then 8 data bits least-significant first, then STOP_BITS high stop bits (default 1).
- R2: Every transmitted bit lasts exactly BIT_CLKS = (CLK_HZ / (BAUD*OVERSAMPLE)) * OVERSAMPLE system clocks. BAUD defaults to 38400, and 9600 must also be legal for the default clock.
- R3: The receiver takes back-to-back frames with either 1 or 2 stop bits, with no change of setting.
- R4: `rx_ready` goes high after a complete frame whose stop bit is high. It stays high for as long as `rd_stb` is not asserted.
- R5: A cycle with `rd_stb` high clears `rx_ready` and `rx_overrun` at the next clock. `rd_data` always shows the last good byte.
- R6: After an accepted write, the start bit begins within a few system clocks after the DELAY_STAGES-th (default 8) rising edge of `phase_clk` that follows the write, and not earlier.
- R7: `tx_busy` rises on an accepted write and falls at the end of the last stop bit. Writes while `tx_busy` is high change nothing on TXD.
- R8: A frame that completes while `rx_ready` is high overwrites `rd_data` and sets `rx_overrun`.
- R9: A low pulse on RXD shorter than half a bit is not taken as a start bit, and `rx_ready` stays low.
- R10: A frame whose stop bit samples low is discarded: `rx_ready` stays low, and the receiver waits for RXD to go high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_clk | input | 1 | Bus phase clock, which paces the transmit delay chain |
| wr_stb | input | 1 | Host write strobe for the data port |
| wr_data | input | DATA_BITS | Byte to transmit |
| rd_stb | input | 1 | Host read strobe for the data port; clears the flags |
| rd_data | output | DATA_BITS | Last received byte |
| rx_ready | output | 1 | Sticky flag: a byte is waiting |
| rx_overrun | output | 1 | A byte was lost before the host read |
| tx_busy | output | 1 | A send is pending or in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The bench counts `phase_clk` edges from the write to the falling edge of the start bit. A chain that is one stage short or long, or that advances on every system clock, gives the wrong count. The bench lets `rx_ready` sit high for hundreds of cycles and then sends a second frame without a read, which exposes a flag that self-clears and a missing overrun or overwrite. Back-to-back frames with 1 and 2 stop bits, a short glitch and a low stop bit probe the receiver's mid-bit start confirmation and its recovery after a framing error. Writes during the delay window and during the stop bit must leave TXD idle afterwards.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("uart_os_tick: TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_every_clk
         assign tick_o = 1'b1;
      end else begin : g_divided
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_port_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 rxd_i,
   output logic                 valid_o,
   output logic [DATA_BITS-1:0] byte_o
);
   localparam int OW = $clog2(OVERSAMPLE);
   localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [OW-1:0] HALF_LAST = OW'(OVERSAMPLE / 2 - 1);
   localparam logic [OW-1:0] FULL_LAST = OW'(OVERSAMPLE - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_rx_core: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_bit;
   rx_state_e              state_q;
   logic [OW-1:0]          os_q;
   logic [IW-1:0]          idx_q;
   logic [DATA_BITS-1:0]   sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      end
   end
   assign rx_bit = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         os_q    <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         case (state_q)
            RX_IDLE: begin
               if (!rx_bit) begin
                  state_q <= RX_START;
                  os_q    <= '0;
               end
            end
            RX_START: begin
               if (tick_i) begin
                  if (os_q == HALF_LAST) begin
                     os_q  <= '0;
                     idx_q <= '0;
                     state_q <= rx_bit ? RX_IDLE : RX_DATA;
                  end else begin
                     os_q <= os_q + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick_i) begin
                  if (os_q == FULL_LAST) begin
                     os_q <= '0;
                     sh_q <= {rx_bit, sh_q[DATA_BITS-1:1]};
                     if (idx_q == IDX_LAST) begin
                        state_q <= RX_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     os_q <= os_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick_i) begin
                  if (os_q == FULL_LAST) begin
                     os_q <= '0;
                     if (rx_bit) begin
                        valid_o <= 1'b1;
                        byte_o  <= sh_q;
                        state_q <= RX_IDLE;
                     end else begin
                        state_q <= RX_BREAK;
                     end
                  end else begin
                     os_q <= os_q + 1'b1;
                  end
               end
            end
            RX_BREAK: begin
               if (rx_bit) begin
                  state_q <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R10
   break_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_BREAK) |=> !valid_o);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
   parameter int BIT_CLKS  = 64,
   parameter int DATA_BITS = 8,
   parameter int STOP_BITS = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [DATA_BITS-1:0] data_i,
   output logic                 txd_o,
   output logic                 done_o
);
   localparam int FRAME = 1 + DATA_BITS + STOP_BITS;
   localparam int TW    = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
   localparam int LW    = $clog2(FRAME);
   localparam logic [TW-1:0] T_LAST = TW'(BIT_CLKS - 1);
   localparam logic [LW-1:0] L_INIT = LW'(FRAME - 1);

   logic [FRAME-1:0] sh_q;
   logic             active_q;
   logic [TW-1:0]    tmr_q;
   logic [LW-1:0]    left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '1;
         active_q <= 1'b0;
         tmr_q    <= '0;
         left_q   <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!active_q) begin
            if (start_i) begin
               sh_q     <= {{STOP_BITS{1'b1}}, data_i, 1'b0};
               active_q <= 1'b1;
               tmr_q    <= '0;
               left_q   <= L_INIT;
            end
         end else if (tmr_q == T_LAST) begin
            tmr_q <= '0;
            sh_q  <= {1'b1, sh_q[FRAME-1:1]};
            if (left_q == '0) begin
               active_q <= 1'b0;
               done_o   <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
            end
         end else begin
            tmr_q <= tmr_q + 1'b1;
         end
      end
   end

   assign txd_o = active_q ? sh_q[0] : 1'b1;

   // R1
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(txd_o));

   // R1
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !active_q) |=> !txd_o);
endmodule

// File: rtl/phase_delay_chain.sv
module phase_delay_chain #(
   parameter int STAGES      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phase_clk_i,
   input  logic arm_i,
   output logic fire_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("phase_delay_chain: STAGES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("phase_delay_chain: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] ps_q;
   logic                   prev_q;
   logic                   adv;
   logic                   pend_q;
   logic [STAGES-1:0]      chain_q;
   logic [STAGES-1:0]      chain_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         ps_q   <= {ps_q[SYNC_STAGES-2:0], phase_clk_i};
         prev_q <= ps_q[SYNC_STAGES-1];
      end
   end
   assign adv = ps_q[SYNC_STAGES-1] & ~prev_q;

   always_comb begin
      chain_d = chain_q;
      if (chain_q[STAGES-1]) begin
         chain_d[STAGES-1] = 1'b0;
      end
      if (adv) begin
         chain_d = {chain_d[STAGES-2:0], pend_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         chain_q <= '0;
      end else begin
         chain_q <= chain_d;
         if (arm_i) begin
            pend_q <= 1'b1;
         end else if (adv) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign fire_o = chain_q[STAGES-1];

   // R6
   single_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pend_q, chain_q}));

   // R6
   fire_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire_o) |-> $past(adv));
endmodule

// File: rtl/bus_uart_port.sv
module bus_uart_port #(
   parameter int CLK_HZ       = 50_000_000,
   parameter int BAUD         = 38400,
   parameter int OVERSAMPLE   = 16,
   parameter int DATA_BITS    = 8,
   parameter int STOP_BITS    = 1,
   parameter int DELAY_STAGES = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 phase_clk,
   input  logic                 wr_stb,
   input  logic [DATA_BITS-1:0] wr_data,
   input  logic                 rd_stb,
   output logic [DATA_BITS-1:0] rd_data,
   output logic                 rx_ready,
   output logic                 rx_overrun,
   output logic                 tx_busy,
   output logic                 txd,
   input  logic                 rxd
);
   localparam int TICK_DIV = CLK_HZ / (BAUD * OVERSAMPLE);
   localparam int BIT_CLKS = TICK_DIV * OVERSAMPLE;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("bus_uart_port: OVERSAMPLE must be even and at least 4");
      end
      if (TICK_DIV < 1) begin : g_bad_rate
         $error("bus_uart_port: CLK_HZ too low for BAUD*OVERSAMPLE");
      end
      if (STOP_BITS != 1 && STOP_BITS != 2) begin : g_bad_stop
         $error("bus_uart_port: STOP_BITS must be 1 or 2");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("bus_uart_port: DATA_BITS out of range");
      end
   endgenerate

   logic                 tick;
   logic                 rx_valid;
   logic [DATA_BITS-1:0] rx_byte;
   logic                 fire;
   logic                 tx_done;
   logic                 accept;
   logic                 busy_q;
   logic [DATA_BITS-1:0] hold_q;
   logic                 ready_q;
   logic                 ovr_q;
   logic [DATA_BITS-1:0] data_q;

   uart_os_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   uart_rx_core #(
      .OVERSAMPLE (OVERSAMPLE),
      .DATA_BITS  (DATA_BITS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .rxd_i  (rxd),
      .valid_o(rx_valid),
      .byte_o (rx_byte)
   );

   phase_delay_chain #(
      .STAGES     (DELAY_STAGES),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_delay (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_clk_i(phase_clk),
      .arm_i      (accept),
      .fire_o     (fire)
   );

   uart_tx_core #(
      .BIT_CLKS (BIT_CLKS),
      .DATA_BITS(DATA_BITS),
      .STOP_BITS(STOP_BITS)
   ) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(fire),
      .data_i (hold_q),
      .txd_o  (txd),
      .done_o (tx_done)
   );

   assign accept = wr_stb & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         hold_q <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            hold_q <= wr_data;
         end else if (tx_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         data_q  <= '0;
      end else if (rx_valid) begin
         data_q  <= rx_byte;
         ready_q <= 1'b1;
         ovr_q   <= (ready_q | ovr_q) & ~rd_stb;
      end else if (rd_stb) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end
   end

   assign rd_data    = data_q;
   assign rx_ready   = ready_q;
   assign rx_overrun = ovr_q;
   assign tx_busy    = busy_q;

   // R4
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rd_stb) |=> rx_ready);

   // R5
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rx_valid) |=> (!rx_ready && !rx_overrun));

   // R8
   overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> rx_ready);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && tx_busy) |=> $stable(hold_q));

   // R7
   fire_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> tx_busy);

   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);
endmodule

// File: tb/bus_uart_port_tb.sv
module bus_uart_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 2_457_600;
   localparam int BAUD       = 38400;
   localparam int OS         = 16;
   localparam int BIT        = (CLK_HZ / (BAUD * OS)) * OS;
   localparam int HALF_PH    = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       phase_clk = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       rx_ready;
   logic       rx_overrun;
   logic       tx_busy;
   logic       txd;
   logic       rxd = 1'b1;

   int total = 0;
   int bad = 0;
   int pcnt = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always #(HALF_PH) phase_clk = ~phase_clk;
   always @(posedge phase_clk) pcnt++;

   bus_uart_port #(
      .CLK_HZ(CLK_HZ),
      .BAUD  (BAUD)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_clk (phase_clk),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .rd_stb    (rd_stb),
      .rd_data   (rd_data),
      .rx_ready  (rx_ready),
      .rx_overrun(rx_overrun),
      .tx_busy   (tx_busy),
      .txd       (txd),
      .rxd       (rxd)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic host_read();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input int nstop, input bit stop_val);
      rxd = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (BIT) @(negedge clk);
      end
      rxd = stop_val;
      repeat (BIT) @(negedge clk);
      for (int s = 1; s < nstop; s++) begin
         rxd = 1'b1;
         repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1;
   endtask

   task automatic test_reset();
      chk(txd == 1'b1, "R1", "txd idle after reset", int'(txd), 1);
      chk(tx_busy == 1'b0, "R7", "busy after reset", int'(tx_busy), 0);
      chk(rx_ready == 1'b0, "R4", "ready after reset", int'(rx_ready), 0);
      chk(rx_overrun == 1'b0, "R8", "overrun after reset", int'(rx_overrun), 0);
   endtask

   task automatic test_tx(input logic [7:0] b, input logic [7:0] junk);
      int p0;
      int w;
      int viol;
      logic [7:0] got;
      @(posedge phase_clk);
      repeat (6) @(negedge clk);
      wr_data = b; wr_stb = 1'b1; p0 = pcnt;
      @(negedge clk); wr_stb = 1'b0;
      chk(tx_busy == 1'b1, "R7", "busy after write", int'(tx_busy), 1);
      repeat (4) @(negedge clk);
      wr_data = junk; wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
      w = 0;
      while (txd == 1'b1 && w < 4000) begin @(negedge clk); w++; end
      chk(pcnt == p0 + 8, "R6", "phase edges before start bit", pcnt - p0, 8);
      w = 0;
      while (txd == 1'b0 && w < 4 * BIT) begin @(negedge clk); w++; end
      chk(w == BIT, "R2", "start bit length", w, BIT);
      repeat (BIT / 2 - 1) @(negedge clk);
      got[0] = txd;
      for (int i = 1; i < 8; i++) begin
         repeat (BIT) @(negedge clk);
         got[i] = txd;
      end
      chk(got == b, "R1", "transmitted byte", int'(got), int'(b));
      repeat (BIT) @(negedge clk);
      chk(txd == 1'b1, "R1", "stop bit level", int'(txd), 1);
      chk(tx_busy == 1'b1, "R7", "busy during stop bit", int'(tx_busy), 1);
      wr_data = junk; wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
      repeat (BIT / 2 + 8) @(negedge clk);
      chk(tx_busy == 1'b0, "R7", "busy after stop bit", int'(tx_busy), 0);
      viol = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (txd == 1'b0 || tx_busy == 1'b1) viol++;
      end
      chk(viol == 0, "R7", "line stays idle after ignored writes", viol, 0);
   endtask

   task automatic test_rx_sticky();
      send_frame(8'h3C, 1, 1'b1);
      repeat (4) @(negedge clk);
      chk(rx_ready == 1'b1, "R4", "ready after frame", int'(rx_ready), 1);
      chk(rd_data == 8'h3C, "R5", "received byte", int'(rd_data), 'h3C);
      repeat (700) @(negedge clk);
      chk(rx_ready == 1'b1, "R4", "ready still set after long wait", int'(rx_ready), 1);
      host_read();
      chk(rx_ready == 1'b0, "R5", "ready cleared by read", int'(rx_ready), 0);
      chk(rd_data == 8'h3C, "R5", "byte kept after read", int'(rd_data), 'h3C);
   endtask

   task automatic test_overrun();
      send_frame(8'h11, 1, 1'b1);
      repeat (BIT) @(negedge clk);
      chk(rx_overrun == 1'b0, "R8", "no overrun on first byte", int'(rx_overrun), 0);
      send_frame(8'hE7, 1, 1'b1);
      repeat (4) @(negedge clk);
      chk(rx_overrun == 1'b1, "R8", "overrun set", int'(rx_overrun), 1);
      chk(rd_data == 8'hE7, "R8", "second byte overwrites", int'(rd_data), 'hE7);
      host_read();
      chk(rx_ready == 1'b0 && rx_overrun == 1'b0, "R5", "read clears both flags",
          int'({rx_ready, rx_overrun}), 0);
   endtask

   task automatic test_back_to_back(input int nstop, input logic [7:0] a, input logic [7:0] b);
      send_frame(a, nstop, 1'b1);
      send_frame(b, nstop, 1'b1);
      repeat (4) @(negedge clk);
      chk(rd_data == b, "R3", "second back-to-back byte", int'(rd_data), int'(b));
      chk(rx_overrun == 1'b1, "R3", "both back-to-back frames seen", int'(rx_overrun), 1);
      host_read();
   endtask

   task automatic test_glitch();
      rxd = 1'b0;
      repeat (BIT / 2 - 12) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * BIT) @(negedge clk);
      chk(rx_ready == 1'b0, "R9", "short glitch ignored", int'(rx_ready), 0);
   endtask

   task automatic test_bad_stop();
      send_frame(8'h5A, 1, 1'b0);
      repeat (12 * BIT) @(negedge clk);
      chk(rx_ready == 1'b0, "R10", "frame with low stop discarded", int'(rx_ready), 0);
      send_frame(8'hC3, 1, 1'b1);
      repeat (4) @(negedge clk);
      chk(rx_ready == 1'b1 && rd_data == 8'hC3, "R10", "good frame after framing error",
          int'(rd_data), 'hC3);
      host_read();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_tx(8'hA5, 8'h00);
      test_tx(8'h5B, 8'h00);
      test_rx_sticky();
      test_overrun();
      test_back_to_back(1, 8'h21, 8'h9E);
      test_back_to_back(2, 8'h7F, 8'h80);
      test_glitch();
      test_bad_stop();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule